// File: doc/BRIEF.md
# Word-Aligned Next-PC Fetch Unit

This block holds the program counter of a single-cycle processor as a word address: bits 1 and 0 of the PC are never stored, because every instruction is four bytes long. Every rising clock edge the stored word address moves forward by one word. When the branch-taken input is high at that edge, the stored word address moves instead by one word plus the sign-extended 16-bit immediate.

The block produces two outputs. One is the 32-bit byte address for instruction memory, formed by appending two zero bits to the stored word address. The other is the byte address of the next sequential instruction, which other parts of the datapath can use. Instruction memory, evaluation of branch conditions, jumps and exceptions are handled elsewhere.

Top module: `pc_fetch_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads the stored word address with parameter RESET_WORD (default 0), so that after the reset edge iaddr equals {RESET_WORD, 2'b00}.
- R2: At a rising edge where rst is low and br_taken is low, the stored word address grows by exactly one.
- R3: At a rising edge where rst is low and br_taken is high, the stored word address becomes old + 1 + imm16 sign-extended to 30 bits. imm16[15] is the sign bit.
- R4: iaddr is the stored word address in bits 31:2 and constant zero in bits 1:0.
- R5: seq_addr is ((stored word address + 1) mod 2^30) in bits 31:2 and zero in bits 1:0. It follows the stored word address combinationally.
- R6: All word arithmetic wraps modulo 2^30. Stepping from word 0x3FFFFFFF gives word 0, and a backward offset from word 0 wraps to the top of the space. No flag is raised.
- R7: br_taken and imm16 are used only at the rising edge. Changing them between edges leaves iaddr unchanged.
- R8: The stored word address changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Branch taken, sampled at the edge |
| imm16 | input | 16 | Signed word offset of the branch |
| iaddr | output | 32 | Instruction byte address |
| seq_addr | output | 32 | Byte address of the next sequential instruction |

## Verification
The register update is due one edge after the stimulus. The bench drives rst, br_taken and imm16 away from the rising edge, waits for exactly one rising edge, and samples iaddr a quarter period later. seq_addr carries no extra delay: it is checked in the same sample window as iaddr. For R7 the inputs are toggled in the middle of a cycle, and iaddr is sampled before the next edge arrives.

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit #(
  parameter int          AW         = 32,
  parameter int          IMM_W      = 16,
  parameter logic [29:0] RESET_WORD = 30'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_taken,
  input  logic [IMM_W-1:0] imm16,
  output logic [AW-1:0]    iaddr,
  output logic [AW-1:0]    seq_addr
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word_q;
  logic [WW-1:0] word_inc;
  logic [WW-1:0] offset;
  logic [WW-1:0] word_d;

  assign word_inc = word_q + 1'b1;
  assign offset   = {{(WW-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign word_d   = br_taken ? word_inc + offset : word_inc;

  always_ff @(posedge clk) begin
    if (rst) word_q <= RESET_WORD[WW-1:0];
    else     word_q <= word_d;
  end

  assign iaddr    = {word_q, 2'b00};
  assign seq_addr = {word_inc, 2'b00};

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> iaddr == {RESET_WORD[WW-1:0], 2'b00}); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    !br_taken |=> iaddr[AW-1:2] == $past(iaddr[AW-1:2]) + 1'b1); // R2
  AST_BRANCH_STEP: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    br_taken |=> iaddr[AW-1:2] == $past(seq_addr[AW-1:2]) + $past({{(WW-IMM_W){imm16[IMM_W-1]}}, imm16})); // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!seen_edge)
    iaddr[1:0] == 2'b00 && seq_addr[1:0] == 2'b00); // R4
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!seen_edge)
    seq_addr[AW-1:2] == iaddr[AW-1:2] + 1'b1); // R5
endmodule

// File: tb/pc_fetch_unit_bench.sv
module pc_fetch_unit_bench;
  localparam time CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        br_taken = 0;
  logic [15:0] imm16 = 0;
  logic [31:0] iaddr, seq_addr;
  int total = 0, bad = 0;
  logic [29:0] model;

  pc_fetch_unit u_pc_fetch_unit (.clk(clk), .rst(rst), .br_taken(br_taken),
    .imm16(imm16), .iaddr(iaddr), .seq_addr(seq_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic br; logic [15:0] imm; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0000}, '{1'b0, 16'h1234}, '{1'b1, 16'h0010}, '{1'b1, 16'hFFFF},
    '{1'b1, 16'hFFF0}, '{1'b0, 16'h8000}, '{1'b1, 16'h7FFF}, '{1'b1, 16'h8000},
    '{1'b1, 16'h0000}, '{1'b0, 16'hFFFF}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] nxt(logic [29:0] w, logic br, logic [15:0] im);
    return br ? w + 30'd1 + {{14{im[15]}}, im} : w + 30'd1;
  endfunction

  task automatic step(input logic br, input logic [15:0] im, input string req);
    br_taken = br; imm16 = im;
    @(posedge clk); #(CLK_PERIOD/4);
    model = nxt(model, br, im);
    check(req, iaddr, {model, 2'b00});
    check("R5", seq_addr, {model + 30'd1, 2'b00});
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    rst = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    model = 30'd0;
    check("R1", iaddr, 32'h0);
    check("R4", {30'd0, iaddr[1:0]}, 32'h0);
    check("R5", seq_addr, 32'h4);
    rst = 0;

    for (int i = 0; i < NV; i++)
      step(VEC[i].br, VEC[i].imm, VEC[i].br ? "R3" : "R2");

    // R7: mid-cycle toggles have no effect before the edge
    br_taken = 1; imm16 = 16'h0100;
    #(CLK_PERIOD/4);
    check("R7", iaddr, {model, 2'b00});
    br_taken = 0; imm16 = 16'hABCD;
    #(CLK_PERIOD/8);
    check("R8", iaddr, {model, 2'b00});
    step(1'b0, 16'h0000, "R7");

    // R6: backward wrap from word 0
    rst = 1; @(posedge clk); #(CLK_PERIOD/4); rst = 0; model = 30'd0;
    check("R1", iaddr, 32'h0);
    step(1'b1, 16'hFFFC, "R6");
    check("R6", iaddr, 32'hFFFF_FFF4);
    // forward wrap across the top
    step(1'b1, 16'h0001, "R6");
    step(1'b0, 16'h0000, "R6");
    check("R6", iaddr, 32'h0);
    step(1'b0, 16'h0000, "R2");
    check("R2", iaddr, 32'h4);

    // reset mid-run returns to start
    step(1'b1, 16'h0040, "R3");
    rst = 1; br_taken = 1; imm16 = 16'h0005;
    @(posedge clk); #(CLK_PERIOD/4); rst = 0; br_taken = 0; model = 30'd0;
    check("R1", iaddr, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule